// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed accumulator as two 32-bit registers, a high half and a low half. Each accepted operation multiplies two signed operands and adds the product to the accumulator. There are two operation kinds. The long kind multiplies the full 32-bit operands. The word kind multiplies only the sign-extended low 16 bits of each operand.

A saturation-enable input selects how the sum is written back. With saturation off, the wrapped 64-bit sum is stored. With saturation on, the two kinds clamp differently. The long kind limits only the high half. It forces the top sixteen bits to ones when the sum is negative. It keeps only the low fifteen bits when the sum is zero or positive. The word kind keeps the whole result within 32 signed bits. On overflow it writes the nearest limit to the low half and sets the high half to 1, which marks that overflow occurred.

Software-style access is limited to what a pipeline needs. Each half can be loaded on its own, a clear input zeroes both halves, and both halves are always visible on output ports. A single-cycle valid pulse marks the cycle in which an accumulate result appears.

Top module: `sat_mac`

## Requirements
- R1: After reset both halves read zero and the result-valid output is low.
- R2: A long operation with saturation off adds the signed 32x32 product of the operands to {high,low}, wrapping modulo 2^64, and both halves show the new value one cycle after the operation is issued.
- R3: A word operation uses only bits 15:0 of each operand, sign-extended. Bits 31:16 of the operands have no effect on the result.
- R4: A long operation with saturation on and a negative 64-bit sum stores the sum with bits 31:16 of the high half forced to one. The low half is the low 32 bits of the sum.
- R5: A long operation with saturation on and a non-negative sum stores a high half whose bits 31:15 are zero and whose bits 14:0 come from the sum. The low half is the low 32 bits of the sum.
- R6: A word operation with saturation on and a sum below -2^31 stores high = 0x00000001 and low = 0x80000000.
- R7: A word operation with saturation on and a sum above 2^31-1 stores high = 0x00000001 and low = 0x7FFFFFFF.
- R8: Clear zeroes both halves at the next edge. It overrides an operation or a load issued in the same cycle, and that operation produces no valid pulse.
- R9: A load strobe for either half writes that half from its data input when neither clear nor an operation is issued. An operation issued in the same cycle wins over a load.
- R10: Result-valid is high for exactly the one cycle after each operation that is not overridden by clear, and low otherwise.
- R11: A word operation with saturation on whose sum lies within the signed 32-bit range stores the full 64-bit sum unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue a multiply-accumulate this cycle |
| op_word | input | 1 | 0 = long (32x32), 1 = word (16x16 from low halves) |
| sat_en | input | 1 | 1 = saturating write-back, 0 = wraparound |
| opnd_a | input | 32 | First multiplicand |
| opnd_b | input | 32 | Second multiplicand |
| clear | input | 1 | Zero both accumulator halves |
| hi_load | input | 1 | Load strobe for the high half |
| hi_wdata | input | 32 | Load value for the high half |
| lo_load | input | 1 | Load strobe for the low half |
| lo_wdata | input | 32 | Load value for the low half |
| acc_hi | output | 32 | Current high half |
| acc_lo | output | 32 | Current low half |
| res_valid | output | 1 | Pulse: last operation's result is visible |

## Verification
Every later accumulate builds on the stored halves, so a wrong high or low half shows on `acc_hi`/`acc_lo` one cycle after the faulty operation. It then stays wrong until a clear or a load overwrites it. The bench uses its own 64-bit integer model of the accumulator and compares both halves and the valid pulse on every cycle. A fault is therefore reported in the cycle it first appears. The saturation branches and the operand-width choice are stressed by directed values placed at the limits: just past ±2^31 in word mode, and sign flips in long mode. Random traffic follows to mix in loads, clears and priority collisions.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic {
    OP_LONG = 1'b0,
    OP_WORD = 1'b1
  } mac_op_e;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int DW = 32,
  parameter int NW = 16
) (
  input  mac_pkg::mac_op_e op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  output logic [2*DW-1:0]  prod
);
  localparam int FW = 2 * DW;

  // sign-extend an operand from the width chosen by the operation kind
  function automatic logic [FW-1:0] widen(input logic [DW-1:0] v, input mac_pkg::mac_op_e k);
    if (k == mac_pkg::OP_WORD) return {{(FW-NW){v[NW-1]}}, v[NW-1:0]};
    return {{(FW-DW){v[DW-1]}}, v};
  endfunction

  // low FW bits of a two's complement product are sign-independent
  function automatic logic [FW-1:0] mul_wrap(input logic [FW-1:0] x, input logic [FW-1:0] y);
    return x * y;
  endfunction

  assign prod = mul_wrap(widen(a, op), widen(b, op));
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate #(
  parameter int DW     = 32,
  parameter int NEG_W  = 16,
  parameter int KEEP_W = 15
) (
  input  logic [2*DW-1:0]  sum,
  input  mac_pkg::mac_op_e op,
  input  logic             sat_en,
  output logic [DW-1:0]    nxt_hi,
  output logic [DW-1:0]    nxt_lo,
  output logic             sum_neg,
  output logic             word_under,
  output logic             word_over
);
  localparam int FW = 2 * DW;
  localparam logic [DW-1:0] NEG_SET  = {{NEG_W{1'b1}}, {(DW-NEG_W){1'b0}}};
  localparam logic [DW-1:0] POS_KEEP = {{(DW-KEEP_W){1'b0}}, {KEEP_W{1'b1}}};
  localparam logic [DW-1:0] LIM_MIN  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] LIM_MAX  = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] OVF_MARK = {{(DW-1){1'b0}}, 1'b1};

  // true when the sum is representable as a signed DW-bit value
  function automatic logic fits_half(input logic [FW-1:0] s);
    return (&s[FW-1:DW-1]) | ~(|s[FW-1:DW-1]);
  endfunction

  function automatic logic [DW-1:0] clamp_long_hi(input logic [DW-1:0] h, input logic neg);
    return neg ? (h | NEG_SET) : (h & POS_KEEP);
  endfunction

  logic in_range;
  assign sum_neg    = sum[FW-1];
  assign in_range   = fits_half(sum);
  assign word_under = sum_neg & ~in_range;
  assign word_over  = ~sum_neg & ~in_range;

  always_comb begin
    nxt_hi = sum[FW-1:DW];
    nxt_lo = sum[DW-1:0];
    if (sat_en) begin
      if (op == mac_pkg::OP_LONG) begin
        nxt_hi = clamp_long_hi(sum[FW-1:DW], sum_neg);
      end else if (word_under) begin
        nxt_hi = OVF_MARK;
        nxt_lo = LIM_MIN;
      end else if (word_over) begin
        nxt_hi = OVF_MARK;
        nxt_lo = LIM_MAX;
      end
    end
  end
endmodule

// File: rtl/sat_mac.sv
module sat_mac #(
  parameter int DW     = 32,
  parameter int NW     = 16,
  parameter int NEG_W  = 16,
  parameter int KEEP_W = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_word,
  input  logic          sat_en,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic          clear,
  input  logic          hi_load,
  input  logic [DW-1:0] hi_wdata,
  input  logic          lo_load,
  input  logic [DW-1:0] lo_wdata,
  output logic [DW-1:0] acc_hi,
  output logic [DW-1:0] acc_lo,
  output logic          res_valid
);
  localparam int FW = 2 * DW;

  mac_pkg::mac_op_e op;
  logic [FW-1:0]    prod;
  logic [FW-1:0]    sum;
  logic [DW-1:0]    nxt_hi, nxt_lo;
  logic             sum_neg, word_under, word_over;
  logic             acc_go;

  assign op     = mac_pkg::mac_op_e'(op_word);
  assign acc_go = op_valid & ~clear;
  assign sum    = {acc_hi, acc_lo} + prod;

  mac_product #(.DW(DW), .NW(NW)) u_prod (
    .op(op), .a(opnd_a), .b(opnd_b), .prod(prod)
  );

  mac_saturate #(.DW(DW), .NEG_W(NEG_W), .KEEP_W(KEEP_W)) u_sat (
    .sum(sum), .op(op), .sat_en(sat_en),
    .nxt_hi(nxt_hi), .nxt_lo(nxt_lo),
    .sum_neg(sum_neg), .word_under(word_under), .word_over(word_over)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_hi    <= '0;
      acc_lo    <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= acc_go;
      if (clear) begin
        acc_hi <= '0;
        acc_lo <= '0;
      end else if (acc_go) begin
        acc_hi <= nxt_hi;
        acc_lo <= nxt_lo;
      end else begin
        if (hi_load) acc_hi <= hi_wdata;
        if (lo_load) acc_lo <= lo_wdata;
      end
    end
  end

  // R8: clear empties both halves and suppresses the pulse
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_hi == '0 && acc_lo == '0 && !res_valid));

  // R10: valid pulse follows an accepted operation only
  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |=> res_valid);
  assert_valid_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_go |=> !res_valid);

  // R4: negative long saturation sets the top of the high half
  assert_long_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && op == mac_pkg::OP_LONG && sat_en && sum_neg)
      |=> (acc_hi[DW-1:DW-NEG_W] == '1));

  // R5: non-negative long saturation clears the high half above KEEP_W
  assert_long_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && op == mac_pkg::OP_LONG && sat_en && !sum_neg)
      |=> (acc_hi[DW-1:KEEP_W] == '0));

  // R6: word underflow clamps to the negative limit with marker
  assert_word_under_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && op == mac_pkg::OP_WORD && sat_en && word_under)
      |=> (acc_hi == DW'(1) && acc_lo == {1'b1, {(DW-1){1'b0}}}));

  // R7: word overflow clamps to the positive limit with marker
  assert_word_over_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && op == mac_pkg::OP_WORD && sat_en && word_over)
      |=> (acc_hi == DW'(1) && acc_lo == {1'b0, {(DW-1){1'b1}}}));

  // R9: an idle-cycle load lands in the high half
  assert_hi_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_load && !op_valid && !clear) |=> (acc_hi == $past(hi_wdata)));
endmodule

// File: tb/sat_mac_tb.sv
module sat_mac_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_word = 1'b0, sat_en = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        clear = 1'b0, hi_load = 1'b0, lo_load = 1'b0;
  logic [31:0] hi_wdata = '0, lo_wdata = '0;
  logic [31:0] acc_hi, acc_lo;
  logic        res_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_hi = '0, m_lo = '0;
  logic        m_vld = 1'b0;

  always #2 clk = ~clk;

  sat_mac u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word), .sat_en(sat_en),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .clear(clear),
    .hi_load(hi_load), .hi_wdata(hi_wdata), .lo_load(lo_load), .lo_wdata(lo_wdata),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .res_valid(res_valid)
  );

  task automatic compare(input string req);
    checks++;
    if (acc_hi !== m_hi || acc_lo !== m_lo || res_valid !== m_vld) begin
      errors++;
      $display("FAIL %s: got hi=%h lo=%h v=%b, expected hi=%h lo=%h v=%b",
               req, acc_hi, acc_lo, res_valid, m_hi, m_lo, m_vld);
    end
  endtask

  // behavioural model of one clock edge
  task automatic model_edge();
    longint acc, p, s;
    m_vld = op_valid && !clear;
    if (clear) begin
      m_hi = 0; m_lo = 0;
    end else if (op_valid) begin
      acc = longint'({m_hi, m_lo});
      if (op_word) p = longint'(shortint'(opnd_a[15:0])) * longint'(shortint'(opnd_b[15:0]));
      else         p = longint'(int'(opnd_a)) * longint'(int'(opnd_b));
      s = acc + p;
      m_hi = s[63:32]; m_lo = s[31:0];
      if (sat_en) begin
        if (!op_word) begin
          if (s < 0) m_hi = m_hi | 32'hFFFF0000;
          else       m_hi = m_hi & 32'h00007FFF;
        end else if (s < -64'sd2147483648) begin
          m_hi = 1; m_lo = 32'h80000000;
        end else if (s > 64'sd2147483647) begin
          m_hi = 1; m_lo = 32'h7FFFFFFF;
        end
      end
    end else begin
      if (hi_load) m_hi = hi_wdata;
      if (lo_load) m_lo = lo_wdata;
    end
  endtask

  task automatic step(input bit v, input bit w, input bit s, input logic [31:0] a, input logic [31:0] b,
                      input bit clr, input bit hl, input logic [31:0] hd, input bit ll, input logic [31:0] ld,
                      input string req);
    op_valid = v; op_word = w; sat_en = s; opnd_a = a; opnd_b = b;
    clear = clr; hi_load = hl; hi_wdata = hd; lo_load = ll; lo_wdata = ld;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(req);
  endtask

  task automatic load(input logic [31:0] h, input logic [31:0] l, input string req);
    step(0, 0, 0, 0, 0, 0, 1, h, 1, l, req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset");

    load(32'h0000_0001, 32'h2000_0000, "R9 load both");
    step(0, 0, 0, 0, 0, 0, 1, 32'hAAAA_5555, 0, 0, "R9 load hi only");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h1234_5678, "R9 load lo only");
    step(1, 0, 0, 32'd3, 32'd5, 0, 1, 32'hDEAD_BEEF, 1, 32'h0, "R9 op beats load");
    step(1, 0, 0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 0, 0, "R2 long negative product");
    step(1, 0, 0, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 0, "R2 long max product");
    load(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 load all ones");
    step(1, 0, 0, 32'd1, 32'd1, 0, 0, 0, 0, 0, "R2 long wrap to zero");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle no pulse");
    step(1, 1, 0, 32'hABCD_FFFE, 32'h1234_0003, 0, 0, 0, 0, 0, "R3 word ignores upper bits");
    step(1, 1, 0, 32'h0000_8000, 32'hFFFF_8000, 0, 0, 0, 0, 0, "R3 word min by min");
    load(32'h8000_1234, 32'h0, "R9 preload");
    step(1, 0, 1, 32'd1, 32'd1, 0, 0, 0, 0, 0, "R4 long sat negative");
    load(32'h1234_5678, 32'h9, "R9 preload");
    step(1, 0, 1, 32'd2, 32'd3, 0, 0, 0, 0, 0, "R5 long sat non-negative");
    load(32'h0, 32'h7FFF_0000, "R9 preload");
    step(1, 1, 1, 32'h0000_7FFF, 32'h0000_7FFF, 0, 0, 0, 0, 0, "R7 word sat above");
    load(32'hFFFF_FFFF, 32'h8000_0000, "R9 preload");
    step(1, 1, 1, 32'h0000_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0, "R6 word sat below");
    load(32'hFFFF_FFFF, 32'h8000_0001, "R9 preload");
    step(1, 1, 1, 32'h0000_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0, "R11 word sat at limit");
    step(1, 1, 1, 32'h0000_0010, 32'h0000_0010, 0, 0, 0, 0, 0, "R11 word sat in range");
    step(1, 0, 0, 32'd7, 32'd9, 1, 1, 32'h5, 1, 32'h6, "R8 clear beats op and load");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 no pulse after clear");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if ((i % 5) == 0) ra = {16'h0, ra[15:0]} | 32'h7FFF;
      step(($urandom % 4) != 0, $urandom % 2, $urandom % 2, ra, rb,
           ($urandom % 16) == 0, ($urandom % 6) == 0, $urandom, ($urandom % 6) == 0, $urandom,
           "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random mix");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule